// File: doc/BRIEF.md
# Fixed-Point Quadratic Evaluator with Register Access

This block is a memory-mapped slave on an AXI4-Lite bus. It evaluates the curve y = A·x² + B·x + C, with A = -0.0088, B = 1.7673 and C = 131.29, which maps a pressure sample to an altitude. Software writes an unsigned 16-bit sample with 12 fractional bits into the input register. The block then runs a fixed five-cycle pipeline. The pipeline squares the sample and forms B·x. It then forms A·x², shifts both products so that they carry 8 fractional bits, and adds C. The 16-bit result has 8 fractional bits and is read back from the result register.

Each coefficient is held at its own scale. A is signed and carries 16 fractional bits (-577). B is unsigned and carries 12 fractional bits (7239). C carries 8 fractional bits (33610). The products are sign-extended before the sum, so the negative A term subtracts correctly. The two register words that do not take part in the computation act as plain read/write storage.

Top module: `qe_quadratic_eval`

## Requirements
- R1: After reset every register reads as zero, including the busy flag and the result.
- R2: A write is accepted in the cycle where both the address and the data are valid. It produces exactly one response, with a response code of 0 (OKAY). Every read also returns a response code of 0. A read can be accepted in every cycle while the read-data ready is held high.
- R3: The register words are addressed by byte offset bits [3:2].
  - Offset 0: bit 0 is a read-only busy flag; bits 31:1 are storage.
  - Offset 4: bits 15:0 hold the input sample; bits 31:16 are storage.
  - Offset 8: all 32 bits are storage.
  - Offset 12: bits 15:0 show the result and ignore writes; bits 31:16 are storage.
- R4: Each write updates only the bytes whose strobe bit is set (strobe bit n covers data bits 8n+7:8n). A write to offset 4 computes from the input word after the strobes have been applied.
- R5: The result is (33610 + floor(-577·x²/2^32) + floor(7239·x/2^16)) mod 2^16, where x is the 16-bit input sample and floor rounds toward minus infinity.
- R6: An input of 0 gives the result 33610.
- R7: The full-scale input 0xA000 (10.0) gives 37908, and the largest input 0xFFFF gives its R5 value without overflow.
- R8: Count the edge that accepts a write to offset 4 as edge 0. A read accepted at edges 0 to 4 returns the previous result. A read accepted at edge 5 returns the new result.
- R9: For the same edge counting, the busy flag reads 1 for reads accepted at edges 1 to 4. It reads 0 for a read accepted at edge 5.
- R10: Back-to-back writes to offset 4 are all computed in order, and the final result matches the last input.
- R11: A write to offset 0, 8 or 12 starts no computation. The busy flag stays 0 and the result does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | ADDR_W | Write address (byte) |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address (byte) |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |

## Verification
The hardest thing to see from the ports is the exact edge where the result register changes and the busy flag drops. An ordinary read sequence takes several cycles, so it cannot land on a chosen edge. To reach that edge, the stimulus holds the read-address valid high from the same cycle that it issues the write to offset 4, with the read-data ready tied high. This captures one read word at every edge from edge 0 to edge 6. The captured words can then be compared one by one against the old and new results and against the busy flag.

// File: rtl/qe_pkg.sv
package qe_pkg;

    localparam int DATA_W  = 32;
    localparam int STRB_W  = DATA_W / 8;
    localparam int NREG    = 4;
    localparam int OFS_W   = $clog2(NREG);
    localparam int X_W     = 16;
    localparam int Y_W     = 16;
    localparam int A_W     = 12;
    localparam int B_W     = 14;
    localparam int A_SHIFT = 32;
    localparam int B_SHIFT = 16;
    localparam int SQ_W    = 2 * X_W;
    localparam int PA_W    = SQ_W + 1 + A_W;
    localparam int PB_W    = X_W + B_W;
    localparam int SUM_W   = Y_W + 2;

    localparam logic signed [A_W-1:0] COEF_A = -12'sd577;
    localparam logic        [B_W-1:0] COEF_B = 14'd7239;
    localparam logic        [Y_W-1:0] COEF_C = 16'd33610;

    localparam logic [1:0] RESP_OKAY = 2'b00;

    typedef enum logic [OFS_W-1:0] {
        REG_CTRL = 2'd0,
        REG_IN   = 2'd1,
        REG_AUX  = 2'd2,
        REG_OUT  = 2'd3
    } reg_idx_e;

    typedef struct packed {
        logic           v;
        logic [X_W-1:0] x;
    } st1_t;

    typedef struct packed {
        logic            v;
        logic [SQ_W-1:0] sq;
        logic [PB_W-1:0] bx;
    } st2_t;

    typedef struct packed {
        logic                   v;
        logic signed [PA_W-1:0] ax2;
        logic        [PB_W-1:0] bx;
    } st3_t;

    typedef struct packed {
        logic                    v;
        logic signed [SUM_W-1:0] ta;
        logic signed [SUM_W-1:0] tb;
    } st4_t;

    function automatic logic [DATA_W-1:0] wr_mask(input int idx);
        case (idx)
            0:       return {{(DATA_W-1){1'b1}}, 1'b0};
            3:       return {{(DATA_W-Y_W){1'b1}}, {Y_W{1'b0}}};
            default: return {DATA_W{1'b1}};
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] merge_bytes(input logic [DATA_W-1:0] old_w,
                                                      input logic [DATA_W-1:0] new_w,
                                                      input logic [STRB_W-1:0] strb);
        logic [DATA_W-1:0] r;
        r = old_w;
        for (int b = 0; b < STRB_W; b++) begin
            if (strb[b]) r[b*8 +: 8] = new_w[b*8 +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/qe_axil_regs.sv
module qe_axil_regs
    import qe_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    s_awaddr,
    input  logic                 s_awvalid,
    output logic                 s_awready,
    input  logic [DATA_W-1:0]    s_wdata,
    input  logic [STRB_W-1:0]    s_wstrb,
    input  logic                 s_wvalid,
    output logic                 s_wready,
    output logic [1:0]           s_bresp,
    output logic                 s_bvalid,
    input  logic                 s_bready,
    input  logic [ADDR_W-1:0]    s_araddr,
    input  logic                 s_arvalid,
    output logic                 s_arready,
    output logic [DATA_W-1:0]    s_rdata,
    output logic [1:0]           s_rresp,
    output logic                 s_rvalid,
    input  logic                 s_rready,
    output logic                 start_o,
    output logic [X_W-1:0]       x_o,
    input  logic                 busy_i,
    input  logic [Y_W-1:0]       result_i
);

    localparam int IDX_LO = 2;

    logic [1:0]        aw_lo_unused;
    logic [1:0]        ar_lo_unused;
    logic [OFS_W-1:0]  wr_idx;
    logic [OFS_W-1:0]  rd_idx;
    logic              wr_fire;
    logic              rd_fire;
    logic              bvalid_q;
    logic              rvalid_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] regs [NREG];
    logic [DATA_W-1:0] in_next;
    logic [DATA_W-1:0] rd_word;

    assign aw_lo_unused = s_awaddr[1:0];
    assign ar_lo_unused = s_araddr[1:0];
    assign wr_idx = s_awaddr[IDX_LO +: OFS_W];
    assign rd_idx = s_araddr[IDX_LO +: OFS_W];

    assign s_awready = s_awvalid & s_wvalid & ~bvalid_q;
    assign s_wready  = s_awready;
    assign wr_fire   = s_awvalid & s_wvalid & ~bvalid_q & ~rst;

    assign s_arready = ~rvalid_q | s_rready;
    assign rd_fire   = s_arvalid & s_arready & ~rst;

    assign s_bvalid = bvalid_q;
    assign s_bresp  = RESP_OKAY;
    assign s_rvalid = rvalid_q;
    assign s_rdata  = rdata_q;
    assign s_rresp  = RESP_OKAY;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr_fire && wr_idx == OFS_W'(g)) begin
                q <= merge_bytes(q, s_wdata, s_wstrb) & wr_mask(g);
            end
        end
        assign regs[g] = q;
    end

    assign in_next = merge_bytes(regs[REG_IN], s_wdata, s_wstrb);
    assign start_o = wr_fire && (wr_idx == REG_IN);
    assign x_o     = in_next[X_W-1:0];

    always_comb begin
        case (rd_idx)
            REG_CTRL: rd_word = regs[REG_CTRL] | {{(DATA_W-1){1'b0}}, busy_i};
            REG_IN:   rd_word = regs[REG_IN];
            REG_AUX:  rd_word = regs[REG_AUX];
            default:  rd_word = regs[REG_OUT] | {{(DATA_W-Y_W){1'b0}}, result_i};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bvalid_q <= 1'b0;
        end else if (wr_fire) begin
            bvalid_q <= 1'b1;
        end else if (s_bready) begin
            bvalid_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else if (rd_fire) begin
            rvalid_q <= 1'b1;
            rdata_q  <= rd_word;
        end else if (s_rready) begin
            rvalid_q <= 1'b0;
        end
    end

    AST_BVALID_HOLD: assert property (@(posedge clk) disable iff (rst)
        s_bvalid && !s_bready |=> s_bvalid) else $error("bvalid dropped"); // R2

    AST_RVALID_HOLD: assert property (@(posedge clk) disable iff (rst)
        s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata)) else $error("rdata unstable"); // R2

endmodule

// File: rtl/qe_poly_pipe.sv
module qe_poly_pipe
    import qe_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           start_i,
    input  logic [X_W-1:0] x_i,
    output logic           busy_o,
    output logic [Y_W-1:0] res_o
);

    st1_t           s1;
    st2_t           s2;
    st3_t           s3;
    st4_t           s4;
    logic [Y_W-1:0] res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1    <= '0;
            s2    <= '0;
            s3    <= '0;
            s4    <= '0;
            res_q <= '0;
        end else begin
            // stage 1: capture the sample
            s1.v <= start_i;
            if (start_i) s1.x <= x_i;
            // stage 2: square and linear product
            s2.v <= s1.v;
            if (s1.v) begin
                s2.sq <= {{X_W{1'b0}}, s1.x} * {{X_W{1'b0}}, s1.x};
                s2.bx <= {{B_W{1'b0}}, s1.x} * {{X_W{1'b0}}, COEF_B};
            end
            // stage 3: signed quadratic product
            s3.v <= s2.v;
            if (s2.v) begin
                s3.ax2 <= $signed({{(PA_W-SQ_W){1'b0}}, s2.sq})
                        * $signed({{(PA_W-A_W){COEF_A[A_W-1]}}, COEF_A});
                s3.bx  <= s2.bx;
            end
            // stage 4: align both terms to 8 fractional bits
            s4.v <= s3.v;
            if (s3.v) begin
                s4.ta <= SUM_W'(s3.ax2 >>> A_SHIFT);
                s4.tb <= SUM_W'(s3.bx >> B_SHIFT);
            end
            // stage 5: add the offset and load the result
            if (s4.v) begin
                res_q <= Y_W'(SUM_W'(COEF_C) + s4.ta + s4.tb);
            end
        end
    end

    assign busy_o = s1.v | s2.v | s3.v | s4.v;
    assign res_o  = res_q;

    AST_LOAD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        $past(start_i, 4) |-> s4.v) else $error("result load late"); // R8

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !s4.v |=> $stable(res_o)) else $error("result moved without load"); // R8

    AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        start_i |=> busy_o) else $error("busy not raised"); // R9

endmodule

// File: rtl/qe_quadratic_eval.sv
module qe_quadratic_eval
    import qe_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [31:0]       s_wdata,
    input  logic [3:0]        s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [31:0]       s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready
);

    logic           start;
    logic [X_W-1:0] x_val;
    logic           busy;
    logic [Y_W-1:0] result;

    qe_axil_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .s_awaddr  (s_awaddr),
        .s_awvalid (s_awvalid),
        .s_awready (s_awready),
        .s_wdata   (s_wdata),
        .s_wstrb   (s_wstrb),
        .s_wvalid  (s_wvalid),
        .s_wready  (s_wready),
        .s_bresp   (s_bresp),
        .s_bvalid  (s_bvalid),
        .s_bready  (s_bready),
        .s_araddr  (s_araddr),
        .s_arvalid (s_arvalid),
        .s_arready (s_arready),
        .s_rdata   (s_rdata),
        .s_rresp   (s_rresp),
        .s_rvalid  (s_rvalid),
        .s_rready  (s_rready),
        .start_o   (start),
        .x_o       (x_val),
        .busy_i    (busy),
        .result_i  (result)
    );

    qe_poly_pipe u_pipe (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .x_i     (x_val),
        .busy_o  (busy),
        .res_o   (result)
    );

endmodule

// File: tb/tb_qe_quadratic_eval.sv
module tb_qe_quadratic_eval;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  awaddr = '0;
    logic        awvalid = 1'b0;
    logic        awready;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        wvalid = 1'b0;
    logic        wready;
    logic [1:0]  bresp;
    logic        bvalid;
    logic        bready = 1'b1;
    logic [3:0]  araddr = '0;
    logic        arvalid = 1'b0;
    logic        arready;
    logic [31:0] rdata;
    logic [1:0]  rresp;
    logic        rvalid;
    logic        rready = 1'b1;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    qe_quadratic_eval #(.ADDR_W(4)) dut (
        .clk(clk), .rst(rst),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready)
    );

    localparam int NVEC = 9;
    localparam logic [15:0] VEC_X [NVEC] = '{
        16'h0000, 16'h0001, 16'h1000, 16'h4000, 16'h8000,
        16'hA000, 16'h199A, 16'hFFFF, 16'h0123
    };

    function automatic logic [15:0] ref_y(input logic [15:0] x);
        longint xv, qa, lb, s;
        xv = longint'(x);
        qa = (-64'sd577 * xv * xv) >>> 32;
        lb = (64'sd7239 * xv) >>> 16;
        s  = 64'sd33610 + qa + lb;
        return s[15:0];
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic axi_write(input logic [3:0] a, input logic [31:0] d, input logic [3:0] st);
        @(negedge clk);
        awaddr = a; wdata = d; wstrb = st; awvalid = 1'b1; wvalid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        awvalid = 1'b0; wvalid = 1'b0;
        chk("R2", "bvalid after write", {31'b0, bvalid}, 32'd1);
        chk("R2", "bresp", {30'b0, bresp}, 32'd0);
    endtask

    task automatic axi_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        araddr = a; arvalid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        arvalid = 1'b0;
        d = rdata;
        if (rvalid !== 1'b1 || rresp !== 2'b00) begin
            checks++; fails++;
            $display("FAIL R2 read response actual=%0b/%0d expected=1/0", rvalid, rresp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R2 watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] cap [7];
        logic [15:0] prev_y;

        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int i = 0; i < 4; i++) begin
            axi_read(4'(i * 4), rd);
            chk("R1", "reset value", rd, 32'd0);
        end

        // R5 R6 R7: vector table walk
        for (int i = 0; i < NVEC; i++) begin
            axi_write(4'h4, {16'h0, VEC_X[i]}, 4'hF);
            idle(8);
            axi_read(4'hC, rd);
            chk(VEC_X[i] == 16'h0 ? "R6" : (VEC_X[i] >= 16'hA000 ? "R7" : "R5"),
                "result", {16'h0, rd[15:0]}, {16'h0, ref_y(VEC_X[i])});
        end
        chk("R6", "zero constant", {16'h0, ref_y(16'h0)}, 32'd33610);
        chk("R7", "full scale constant", {16'h0, ref_y(16'hA000)}, 32'd37908);

        // R3: storage and read-only fields
        axi_write(4'h8, 32'hDEADBEEF, 4'hF);
        axi_read(4'h8, rd);
        chk("R3", "offset 8 storage", rd, 32'hDEADBEEF);
        axi_write(4'h0, 32'hFFFFFFFF, 4'hF);
        axi_read(4'h0, rd);
        chk("R3", "offset 0 busy read-only", rd, 32'hFFFFFFFE);
        prev_y = ref_y(16'h0123);
        axi_write(4'hC, 32'h12345678, 4'hF);
        axi_read(4'hC, rd);
        chk("R3", "offset 12 upper store, result kept", rd, {16'h1234, prev_y});

        // R4: byte strobes
        axi_write(4'h8, 32'h11223344, 4'b0101);
        axi_read(4'h8, rd);
        chk("R4", "strobed storage", rd, 32'hDE22BE44);
        axi_write(4'h4, 32'h00001000, 4'hF);
        idle(8);
        axi_write(4'h4, 32'hAABB00FF, 4'b0001);
        idle(8);
        axi_read(4'h4, rd);
        chk("R4", "strobed input word", rd, 32'h000010FF);
        axi_read(4'hC, rd);
        chk("R4", "result from merged input", {16'h0, rd[15:0]}, {16'h0, ref_y(16'h10FF)});
        prev_y = ref_y(16'h10FF);

        // R11: other offsets start nothing
        axi_write(4'h8, 32'h0, 4'hF);
        axi_read(4'h0, rd);
        chk("R11", "busy after offset 8 write", {31'b0, rd[0]}, 32'd0);
        axi_write(4'hC, 32'h0, 4'hF);
        idle(8);
        axi_read(4'hC, rd);
        chk("R11", "result after offset 12 write", rd, {16'h0, prev_y});

        // R8: result turnover edge, one read captured per edge
        @(negedge clk);
        awaddr = 4'h4; wdata = 32'h00008000; wstrb = 4'hF; awvalid = 1'b1; wvalid = 1'b1;
        araddr = 4'hC; arvalid = 1'b1;
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            awvalid = 1'b0; wvalid = 1'b0;
            cap[k] = rdata;
        end
        arvalid = 1'b0;
        for (int k = 0; k < 7; k++) begin
            chk("R8", $sformatf("result at edge %0d", k), {16'h0, cap[k][15:0]},
                {16'h0, (k < 5) ? prev_y : ref_y(16'h8000)});
        end
        idle(4);

        // R9: busy window, one read captured per edge
        @(negedge clk);
        awaddr = 4'h4; wdata = 32'h00002000; wstrb = 4'hF; awvalid = 1'b1; wvalid = 1'b1;
        araddr = 4'h0; arvalid = 1'b1;
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            awvalid = 1'b0; wvalid = 1'b0;
            cap[k] = rdata;
        end
        arvalid = 1'b0;
        for (int k = 0; k < 7; k++) begin
            chk("R9", $sformatf("busy at edge %0d", k), {31'b0, cap[k][0]},
                (k >= 1 && k <= 4) ? 32'd1 : 32'd0);
        end
        idle(4);

        // R10: back-to-back inputs
        axi_write(4'h4, 32'h00003000, 4'hF);
        axi_write(4'h4, 32'h00007777, 4'hF);
        axi_write(4'h4, 32'h00009ABC, 4'hF);
        idle(8);
        axi_read(4'hC, rd);
        chk("R10", "last of back-to-back", {16'h0, rd[15:0]}, {16'h0, ref_y(16'h9ABC)});

        // R1: reset again clears everything
        @(negedge clk); rst = 1'b1;
        idle(3);
        rst = 1'b0;
        axi_read(4'hC, rd);
        chk("R1", "result after reset", rd, 32'd0);
        axi_read(4'h8, rd);
        chk("R1", "storage after reset", rd, 32'd0);

        finish_run();
    end

endmodule